// File: doc/BRIEF.md
# UART Register Front End

This block is the bus-side half of a simple serial port. A host accesses a small map of 32-bit registers to queue outgoing bytes, collect incoming bytes, set watermark thresholds, enable interrupts and store a baud divisor. Two eight-entry byte queues sit between the register port and two byte streams that carry valid/ready handshakes. These streams connect to an external shifter, which does the serialization, deserialization and bit timing. This block does none of that work. It only holds the divisor and drives it out on a port.

The host port has no wait states. Read data is combinational from the request in the same cycle. Writes and the pop caused by a receive read take effect at the next rising clock edge. The block raises one level-sensitive interrupt. The interrupt is driven directly from the enable register and the receive queue occupancy, so it follows a state change within the same cycle in which that change lands.

Top module: `uart_reg_front`

## Requirements
- R1: Only accesses with `be_i` equal to 4'hF are decoded. Register offsets are 0x00 tx data, 0x04 rx data, 0x08 tx control, 0x0C rx control, 0x10 interrupt enable, 0x14 interrupt pending and 0x18 divisor. Any other offset, and any access without all four byte enables, reads as zero and leaves all state unchanged.
- R2: A write to 0x00 queues `wdata_i[7:0]`. The tx stream offers the oldest queued byte only while tx control bit 0 (transmit enable) is set. The byte is removed in the cycle in which `tx_valid_o` and `tx_ready_i` are both high. Bytes leave in write order.
- R3: A write to 0x00 while the tx queue holds 8 bytes is discarded, and `tx_ovf_o` is high for exactly the following cycle.
- R4: A read of 0x00 returns 0x80000000 while the tx queue is full and 0 otherwise.
- R5: `rx_ready_o` is high only when rx control bit 0 (receive enable) is set and the rx queue holds fewer than 8 bytes. A byte offered while `rx_ready_o` is low is dropped.
- R6: A read of 0x04 with the rx queue not empty returns the oldest byte in bits [7:0], with the upper bits zero, and removes that byte.
- R7: A read of 0x04 with the rx queue empty returns 0x80000000 and removes nothing.
- R8: Pending bit 0 reads 1 exactly when tx control bits [18:16] are nonzero.
- R9: Pending bit 1 reads 1 exactly when the rx queue occupancy is strictly greater than rx control bits [18:16].
- R10: `irq_o` is high when enable bit 0 is set, or when enable bit 1 is set and the rx queue is not empty. Otherwise it is low.
- R11: Tx and rx control read back bits 0 and [18:16] only. The enable register reads back bits [1:0]. The divisor reads back its low DIV_W bits and drives `div_o`. All other bits read zero.
- R12: While `rst_ni` is low, control, enable and divisor registers clear, both queues empty, and `irq_o`, `tx_valid_o`, `rx_ready_o` and `tx_ovf_o` are low.
- R13: The pending register at 0x14 is read-only. Writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| be_i | input | 4 | Byte enables; only 4'hF is decoded |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle as request |
| tx_data_o | output | 8 | Outgoing byte |
| tx_valid_o | output | 1 | Outgoing byte valid |
| tx_ready_i | input | 1 | Shifter accepts outgoing byte |
| tx_ovf_o | output | 1 | One-cycle pulse on a discarded tx write |
| rx_data_i | input | 8 | Incoming byte |
| rx_valid_i | input | 1 | Incoming byte valid |
| rx_ready_o | output | 1 | Block accepts incoming byte |
| div_o | output | DIV_W | Stored baud divisor |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is due in the same cycle as the request. The bench drives each access on a falling edge and samples `rdata_o` shortly after, before the rising edge commits any pop. Register writes, queue pushes and pops land on the next rising edge, so pending bits, `irq_o`, `rx_ready_o` and `tx_valid_o` are checked at the falling edge that follows. `tx_ovf_o` is registered and is checked at that same falling edge. A scoreboard queue collects every accepted tx byte. A monitor pops an entry at each falling edge where valid and ready are both high, which is the edge just before the transfer takes place, and compares it with the byte on `tx_data_o`.

// File: rtl/uart_front_pkg.sv
package uart_front_pkg;
  localparam logic [7:0] OFF_TXDATA = 8'h00;
  localparam logic [7:0] OFF_RXDATA = 8'h04;
  localparam logic [7:0] OFF_TXCTRL = 8'h08;
  localparam logic [7:0] OFF_RXCTRL = 8'h0C;
  localparam logic [7:0] OFF_IE     = 8'h10;
  localparam logic [7:0] OFF_IP     = 8'h14;
  localparam logic [7:0] OFF_DIV    = 8'h18;

  localparam int WM_W   = 3;
  localparam int WM_LSB = 16;
  localparam int IRQ_TX = 0;
  localparam int IRQ_RX = 1;

  localparam logic [31:0] RX_EMPTY_WORD = 32'h8000_0000;

  typedef struct packed {
    logic            en;
    logic [WM_W-1:0] wm;
  } chan_ctrl_t;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [CW-1:0]    wp_q, rp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (pop_i)  rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q[AW-1:0]] <= wdata_i;
  end

  assign count_o = wp_q - rp_q;
  assign full_o  = (count_o == CW'(DEPTH));
  assign empty_o = (count_o == '0);
  assign rdata_o = mem_q[rp_q[AW-1:0]];

  // R5
  push_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R6
  pop_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  // R3
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_front_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [1:0]      ie_i,
  input  logic [WM_W-1:0] tx_wm_i,
  input  logic [WM_W-1:0] rx_wm_i,
  input  logic [CW-1:0]   rx_count_i,
  output logic [1:0]      ip_o,
  output logic            irq_o
);
  always_comb begin
    ip_o         = '0;
    ip_o[IRQ_TX] = (tx_wm_i != '0);
    ip_o[IRQ_RX] = (32'(rx_count_i) > 32'(rx_wm_i));
  end

  assign irq_o = ie_i[IRQ_TX] | (ie_i[IRQ_RX] & (rx_count_i != '0));
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_front_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              tx_ovf_o,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              irq_o
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [7:0] off;
  logic       acc, wr, rd;
  assign off = 8'(addr_i);
  assign acc = req_i && (be_i == 4'hF);
  assign wr  = acc && we_i;
  assign rd  = acc && !we_i;

  chan_ctrl_t       tx_ctrl_q, rx_ctrl_q;
  logic [1:0]       ie_q;
  logic [DIV_W-1:0] div_q;
  logic             ovf_q;

  logic [7:0]    tx_head, rx_head;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_count, rx_count;
  logic          tx_push, tx_pop, rx_push, rx_pop, tx_wr;
  logic [1:0]    ip;

  assign tx_wr   = wr && (off == OFF_TXDATA);
  assign tx_push = tx_wr && !tx_full;
  assign tx_pop  = tx_valid_o && tx_ready_i;
  assign rx_push = rx_valid_i && rx_ready_o;
  assign rx_pop  = rd && (off == OFF_RXDATA) && !rx_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ctrl_q <= '0;
      rx_ctrl_q <= '0;
      ie_q      <= '0;
      div_q     <= '0;
      ovf_q     <= 1'b0;
    end else begin
      ovf_q <= tx_wr && tx_full;
      if (wr) begin
        unique case (off)
          OFF_TXCTRL: tx_ctrl_q <= '{en: wdata_i[0], wm: wdata_i[WM_LSB +: WM_W]};
          OFF_RXCTRL: rx_ctrl_q <= '{en: wdata_i[0], wm: wdata_i[WM_LSB +: WM_W]};
          OFF_IE:     ie_q      <= wdata_i[1:0];
          OFF_DIV:    div_q     <= wdata_i[DIV_W-1:0];
          default: ;
        endcase
      end
    end
  end

  uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_tx_fifo (
    .clk_i, .rst_ni, .push_i(tx_push), .wdata_i(wdata_i[7:0]), .pop_i(tx_pop),
    .rdata_o(tx_head), .full_o(tx_full), .empty_o(tx_empty), .count_o(tx_count)
  );

  uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rx_fifo (
    .clk_i, .rst_ni, .push_i(rx_push), .wdata_i(rx_data_i), .pop_i(rx_pop),
    .rdata_o(rx_head), .full_o(rx_full), .empty_o(rx_empty), .count_o(rx_count)
  );

  uart_irq_ctrl #(.CW(CW)) u_irq (
    .ie_i(ie_q), .tx_wm_i(tx_ctrl_q.wm), .rx_wm_i(rx_ctrl_q.wm),
    .rx_count_i(rx_count), .ip_o(ip), .irq_o(irq_o)
  );

  function automatic logic [31:0] ctrl_word(chan_ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[0] = c.en;
    w[WM_LSB +: WM_W] = c.wm;
    return w;
  endfunction

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (off)
        OFF_TXDATA: rdata_o = tx_full ? 32'h8000_0000 : 32'h0;
        OFF_RXDATA: rdata_o = rx_empty ? RX_EMPTY_WORD : {24'h0, rx_head};
        OFF_TXCTRL: rdata_o = ctrl_word(tx_ctrl_q);
        OFF_RXCTRL: rdata_o = ctrl_word(rx_ctrl_q);
        OFF_IE:     rdata_o = {30'h0, ie_q};
        OFF_IP:     rdata_o = {30'h0, ip};
        OFF_DIV:    rdata_o = 32'(div_q);
        default:    rdata_o = '0;
      endcase
    end
  end

  assign tx_data_o  = tx_head;
  assign tx_valid_o = tx_ctrl_q.en && !tx_empty;
  assign rx_ready_o = rx_ctrl_q.en && !rx_full;
  assign tx_ovf_o   = ovf_q;
  assign div_o      = div_q;

  // R3
  tx_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr && tx_count == CW'(DEPTH)) |=> tx_ovf_o);
  // R10
  irq_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && off == OFF_IE && wdata_i[IRQ_TX]) |=> irq_o);
  // R7
  rx_empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && off == OFF_RXDATA && rx_count == '0) |-> (rdata_o[31] && rdata_o[7:0] == 8'h0));
  // R2
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !(wr && off == OFF_TXCTRL)) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

// File: tb/uart_reg_front_test.sv
`timescale 1ns/1ps
module uart_reg_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o, tx_ready_i = 1'b0, tx_ovf_o;
  logic [7:0]  rx_data_i = '0;
  logic        rx_valid_i = 1'b0, rx_ready_o;
  logic [DIV_W-1:0] div_o;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;
  int ready_mode = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uart_reg_front #(.DEPTH(8), .DIV_W(DIV_W), .ADDR_W(5)) uut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .be_i, .wdata_i, .rdata_o,
    .tx_data_o, .tx_valid_o, .tx_ready_i, .tx_ovf_o,
    .rx_data_i, .rx_valid_i, .rx_ready_o, .div_o, .irq_o
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a[4:0]; wdata_i = d; be_i = be;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; be_i = '0;
    #1;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a[4:0]; be_i = be;
    #1 d = rdata_o;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; be_i = '0;
    #1;
  endtask

  task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    bus_read(a, d);
    check(d === exp, req, d, exp);
  endtask

  task automatic tx_send(input logic [7:0] b);
    bus_write(8'h00, {24'hABCDEF, b});
  endtask

  task automatic rx_offer(input logic [7:0] b);
    logic acc;
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_data_i = b;
    #1 acc = rx_ready_o;
    @(posedge clk_i);
    @(negedge clk_i);
    rx_valid_i = 1'b0;
    if (acc) rx_q.push_back(b);
    #1;
  endtask

  // tx ready pattern
  initial forever begin
    @(negedge clk_i);
    case (ready_mode)
      0: tx_ready_i = 1'b0;
      1: tx_ready_i = 1'b1;
      default: tx_ready_i = ~tx_ready_i;
    endcase
  end

  // tx monitor: transfer occurs at the next rising edge
  initial forever begin
    @(negedge clk_i);
    #2;
    if (rst_ni && tx_valid_o && tx_ready_i) begin
      if (tx_q.size() == 0) check(1'b0, "R2 unexpected byte", {24'h0, tx_data_o}, 32'h0);
      else begin
        logic [7:0] e;
        e = tx_q.pop_front();
        check(tx_data_o === e, "R2 tx order", {24'h0, tx_data_o}, {24'h0, e});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    // R12 reset state, sampled while reset held
    check(irq_o === 1'b0 && tx_valid_o === 1'b0 && rx_ready_o === 1'b0 && tx_ovf_o === 1'b0,
          "R12 outputs in reset", {28'h0, irq_o, tx_valid_o, rx_ready_o, tx_ovf_o}, 32'h0);
    rst_ni = 1'b1;
    read_chk(8'h08, 32'h0, "R12 txctrl");
    read_chk(8'h0C, 32'h0, "R12 rxctrl");
    read_chk(8'h10, 32'h0, "R12 ie");
    read_chk(8'h18, 32'h0, "R12 div");
    read_chk(8'h04, 32'h8000_0000, "R12 rx empty");
    read_chk(8'h00, 32'h0, "R12 tx not full");

    // R11 readback masking, R8 tx watermark pending
    bus_write(8'h08, 32'hFFFF_FFFE);
    read_chk(8'h08, 32'h0007_0000, "R11 txctrl mask");
    read_chk(8'h14, 32'h1, "R8 tx wm set");
    bus_write(8'h08, 32'h0000_0000);
    read_chk(8'h14, 32'h0, "R8 tx wm clear");
    bus_write(8'h18, 32'h1234_5678);
    read_chk(8'h18, 32'h0000_5678, "R11 div readback");
    check(div_o === 16'h5678, "R11 div_o", {16'h0, div_o}, 32'h5678);
    bus_write(8'h10, 32'hFFFF_FFFC);
    read_chk(8'h10, 32'h0, "R11 ie mask");

    // R1 partial and unmapped accesses
    bus_write(8'h18, 32'hFFFF_FFFF, 4'h3);
    read_chk(8'h18, 32'h0000_5678, "R1 partial write ignored");
    bus_write(8'h1C, 32'hFFFF_FFFF);
    read_chk(8'h1C, 32'h0, "R1 unmapped read");
    bus_read(8'h18, d, 4'h7);
    check(d === 32'h0, "R1 partial read", d, 32'h0);
    bus_write(8'h00, 32'h55, 4'h1);
    read_chk(8'h00, 32'h0, "R1 partial tx write");
    check(tx_valid_o === 1'b0, "R1 no tx queued", {31'h0, tx_valid_o}, 32'h0);

    // R10 tx enable raises irq; R13 pending read-only
    bus_write(8'h10, 32'h1);
    check(irq_o === 1'b1, "R10 irq tx enable", {31'h0, irq_o}, 32'h1);
    bus_write(8'h14, 32'h3);
    read_chk(8'h14, 32'h0, "R13 pending read-only");
    bus_write(8'h10, 32'h0);
    check(irq_o === 1'b0, "R10 irq off", {31'h0, irq_o}, 32'h0);

    // R2/R3/R4 tx queue with transmit disabled
    for (int i = 0; i < 8; i++) begin
      tx_send(8'h10 + 8'(i));
      tx_q.push_back(8'h10 + 8'(i));
    end
    check(tx_valid_o === 1'b0, "R2 held while disabled", {31'h0, tx_valid_o}, 32'h0);
    read_chk(8'h00, 32'h8000_0000, "R4 tx full flag");
    tx_send(8'hEE);
    check(tx_ovf_o === 1'b1, "R3 overflow pulse", {31'h0, tx_ovf_o}, 32'h1);
    @(negedge clk_i); #1;
    check(tx_ovf_o === 1'b0, "R3 pulse one cycle", {31'h0, tx_ovf_o}, 32'h0);

    ready_mode = 2;
    bus_write(8'h08, 32'h1);
    repeat (40) @(negedge clk_i);
    #3;
    check(tx_q.size() == 0, "R2 all drained", tx_q.size(), 32'h0);
    check(tx_valid_o === 1'b0, "R2 valid low when empty", {31'h0, tx_valid_o}, 32'h0);
    read_chk(8'h00, 32'h0, "R4 tx flag cleared");

    // second pattern, ready held high, writes while streaming
    ready_mode = 1;
    for (int i = 0; i < 5; i++) begin
      tx_send(8'hA0 ^ 8'(i * 7));
      tx_q.push_back(8'hA0 ^ 8'(i * 7));
    end
    repeat (10) @(negedge clk_i);
    #3;
    check(tx_q.size() == 0, "R2 streaming drained", tx_q.size(), 32'h0);
    ready_mode = 0;

    // rx side: disabled drops
    rx_offer(8'h99);
    read_chk(8'h04, 32'h8000_0000, "R5 disabled rx dropped");
    bus_write(8'h0C, 32'h0002_0001);
    bus_write(8'h10, 32'h2);
    check(irq_o === 1'b0, "R10 rx enable, empty", {31'h0, irq_o}, 32'h0);
    rx_offer(8'h31);
    check(irq_o === 1'b1, "R10 rx irq nonempty", {31'h0, irq_o}, 32'h1);
    read_chk(8'h14, 32'h0, "R9 count1 vs 2");
    rx_offer(8'h32);
    read_chk(8'h14, 32'h0, "R9 count2 vs 2");
    rx_offer(8'h33);
    read_chk(8'h14, 32'h2, "R9 count3 vs 2");
    for (int i = 0; i < 5; i++) rx_offer(8'h40 + 8'(i));
    check(rx_ready_o === 1'b0, "R5 ready low when full", {31'h0, rx_ready_o}, 32'h0);
    rx_offer(8'hEE);
    check(rx_q.size() == 8, "R5 full drop", rx_q.size(), 32'd8);
    while (rx_q.size() > 0) begin
      logic [7:0] e;
      e = rx_q.pop_front();
      read_chk(8'h04, {24'h0, e}, "R6 rx order");
    end
    read_chk(8'h04, 32'h8000_0000, "R7 empty read");
    read_chk(8'h04, 32'h8000_0000, "R7 empty read again");
    check(irq_o === 1'b0, "R10 irq low when drained", {31'h0, irq_o}, 32'h0);
    check(rx_ready_o === 1'b1, "R5 ready after drain", {31'h0, rx_ready_o}, 32'h1);
    bus_write(8'h10, 32'h3);
    check(irq_o === 1'b1, "R10 both enables", {31'h0, irq_o}, 32'h1);

    // R12 reset clears queued rx and registers
    rx_offer(8'h77);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(irq_o === 1'b0 && rx_ready_o === 1'b0, "R12 async reset",
          {30'h0, irq_o, rx_ready_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    read_chk(8'h04, 32'h8000_0000, "R12 rx emptied");
    read_chk(8'h18, 32'h0, "R12 div cleared");
    rx_q.delete();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule